// File: doc/BRIEF.md
# Fowler Multi-Sample Pixel Differencer

This block turns a stream of digitized samples from a non-destructively read image sensor into difference images. After each pixel reset, the sensor is read several times right away to give "pedestal" frames. Just before the next reset it is read the same number of times again to give "signal" frames. The block keeps a running per-pixel sum of the pedestal frames and a second sum of the signal frames. While the final signal frame streams in, it emits for every pixel the signal average minus the pedestal average. With one frame of each kind this is plain correlated double sampling. A raw mode passes the signal frame straight through with no differencing.

Each incoming frame is raster ordered and starts with one reference row held at reset, which the block discards. The frame kind is a tag sampled together with the start-of-frame marker. The sample count N is a power of two, so both averages are right shifts of the sums. Both sums are held in on-chip arrays of depth ROWS*COLS. A sequence that is broken by a pedestal frame in the middle of the signal frames starts over. A signal frame that arrives too early is dropped. In both cases a sticky error flag is raised.

Top module: `fowler_differencer`

## Requirements
- R1: While rst_ni is low and on the first cycle after it is released, out_valid_o and seq_err_o are 0.
- R2: A frame is ROWS+1 rows of COLS beats and opens with the beat that has in_sof_i=1. Its first COLS beats (the reference row) are never accumulated and never emitted, and beats after row ROWS+1 are ignored.
- R3: With N = 2^cfg_log_n_i (cfg_log_n_i 0..3), each emitted value is floor(S/N) - floor(P/N) as a signed DATA_W+1 bit number. P is the sum of the pixel's N pedestal samples and S is the sum of its N signal samples. cfg_log_n_i is sampled at the start-of-frame beat of the first pedestal frame of a sequence.
- R4: With cfg_log_n_i = 0 (N = 1), the output is signal sample minus pedestal sample.
- R5: A result appears on out_valid_o/out_data_o exactly one cycle after the matching pixel beat of the N-th signal frame, in raster order.
- R6: After the N-th signal frame, the next pedestal frame starts a fresh sequence without error. A pedestal frame that arrives when N pedestal frames are already held (and no signal frame has come yet) also restarts without error.
- R7: When cfg_raw_i is 1 at a start-of-frame beat, a signal-tagged frame has every pixel emitted unchanged (zero-extended) one cycle later, a pedestal-tagged frame emits nothing, and the pedestal count is cleared.
- R8: A pedestal frame arriving after at least one signal frame of the sequence restarts the sequence, with that frame as pedestal sample 1, and sets seq_err_o. seq_err_o then stays 1 until reset.
- R9: A signal frame arriving before N pedestal frames are held is dropped: it gives no output, and seq_err_o is set one cycle after its start-of-frame beat.
- R10: in_signal_i is read only on the start-of-frame beat (1 = signal, 0 = pedestal), and beats with in_valid_i = 0 have no effect.
- R11: Pedestal frames and signal frames other than the N-th produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_log_n_i | input | LOGN_W | log2 of samples per sequence |
| cfg_raw_i | input | 1 | Raw single-sample mode, sampled at start of frame |
| in_valid_i | input | 1 | Sample beat valid |
| in_sof_i | input | 1 | First beat of a frame |
| in_signal_i | input | 1 | Frame kind at start of frame: 1 signal, 0 pedestal |
| in_data_i | input | DATA_W | Unsigned pixel sample |
| out_valid_o | output | 1 | Result valid |
| out_data_o | output | DATA_W+1 | Signed difference or raw sample |
| seq_err_o | output | 1 | Sticky sequence error |

## Verification
A wrong frame count or a wrong frame-kind decision shows up at the end of the sequence. Results then come out a frame early or late, or they are missing, so the per-cycle comparison flags the first beat of the wrong frame. A corrupted sum entry or an address that is off by one only shows in the values emitted during the last signal frame. That is why every sequence uses pixel patterns that differ between pixels and between frames, and the reference row carries its own values. Errors in the sequence-error logic are visible on seq_err_o one cycle after the offending start-of-frame beat.

// File: rtl/fowler_pkg.sv
package fowler_pkg;
  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_PED  = 2'd1,
    FM_SIG  = 2'd2,
    FM_RAW  = 2'd3
  } frame_mode_e;

  typedef struct packed {
    frame_mode_e mode;
    logic        first;
    logic        last;
  } frame_ctl_t;
endpackage

// File: rtl/fowler_frame_seq.sv
module fowler_frame_seq
  import fowler_pkg::*;
#(
  parameter int MAX_LOG_N = 3,
  parameter int LOGN_W    = 2,
  localparam int CNT_W    = MAX_LOG_N + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic              sof_i,
  input  logic              tag_sig_i,
  input  logic              raw_i,
  input  logic [LOGN_W-1:0] log_n_i,
  output frame_ctl_t        ctl_o,
  output logic [LOGN_W-1:0] log_o,
  output logic              ped_full_o,
  output logic              err_o
);
  frame_ctl_t        ctl_q, dec;
  logic [CNT_W-1:0]  ped_q, sig_q, ped_d, sig_d, n_q;
  logic [LOGN_W-1:0] log_q, log_d;
  logic              set_err, start;

  assign start      = beat_i & sof_i;
  assign n_q        = CNT_W'(1) << log_q;
  assign ped_full_o = (ped_q == n_q);

  always_comb begin
    dec     = '{mode: FM_IDLE, first: 1'b0, last: 1'b0};
    ped_d   = ped_q;
    sig_d   = sig_q;
    log_d   = log_q;
    set_err = 1'b0;
    if (raw_i) begin
      dec.mode = tag_sig_i ? FM_RAW : FM_IDLE;
      ped_d    = '0;
      sig_d    = '0;
    end else if (!tag_sig_i) begin
      dec.mode = FM_PED;
      if (sig_q != '0 || ped_q == '0 || ped_q >= n_q) begin
        // new sequence: first pedestal overwrites the sums
        set_err   = (sig_q != '0);
        dec.first = 1'b1;
        log_d     = log_n_i;
        ped_d     = CNT_W'(1);
        sig_d     = '0;
      end else begin
        ped_d = ped_q + CNT_W'(1);
      end
    end else if (!ped_full_o) begin
      set_err = 1'b1;
    end else begin
      dec.mode  = FM_SIG;
      dec.first = (sig_q == '0);
      dec.last  = (sig_q == n_q - CNT_W'(1));
      if (dec.last) begin
        ped_d = '0;
        sig_d = '0;
      end else begin
        sig_d = sig_q + CNT_W'(1);
      end
    end
  end

  assign ctl_o = start ? dec : ctl_q;
  assign log_o = start ? log_d : log_q;
  assign err_o = set_err & start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{mode: FM_IDLE, first: 1'b0, last: 1'b0};
      ped_q <= '0;
      sig_q <= '0;
      log_q <= '0;
    end else if (start) begin
      ctl_q <= dec;
      ped_q <= ped_d;
      sig_q <= sig_d;
      log_q <= log_d;
    end
  end
endmodule

// File: rtl/fowler_pix_count.sv
module fowler_pix_count #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int FRAME_BEATS = (ROWS + 1) * COLS,
  localparam int CNT_W  = $clog2(FRAME_BEATS + 1),
  localparam int ADDR_W = $clog2(ROWS * COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic              sof_i,
  output logic              is_data_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0] cnt_q, cur;

  assign cur       = sof_i ? '0 : cnt_q;
  assign is_data_o = beat_i && (cur >= CNT_W'(COLS)) && (cur < CNT_W'(FRAME_BEATS));
  assign addr_o    = ADDR_W'(cur - CNT_W'(COLS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_W'(FRAME_BEATS);  // nothing counts before a start of frame
    else if (beat_i) cnt_q <= (cur == CNT_W'(FRAME_BEATS)) ? cur : cur + CNT_W'(1);
  end
endmodule

// File: rtl/fowler_acc_mem.sv
module fowler_acc_mem #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 12,
  parameter int ACC_W   = 15,
  parameter bit OUT_SUM = 1'b0,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              first_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  q_o
);
  logic [ACC_W-1:0] mem [DEPTH];
  logic [ACC_W-1:0] stored, sum;

  assign stored = mem[addr_i];
  assign sum    = first_i ? ACC_W'(data_i) : stored + ACC_W'(data_i);

  generate
    if (OUT_SUM) begin : g_sum
      assign q_o = sum;
    end else begin : g_stored
      assign q_o = stored;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= sum;
  end
endmodule

// File: rtl/fowler_differencer.sv
module fowler_differencer
  import fowler_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int MAX_LOG_N = 3,
  localparam int LOGN_W   = (MAX_LOG_N > 0) ? $clog2(MAX_LOG_N + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOGN_W-1:0] cfg_log_n_i,
  input  logic              cfg_raw_i,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic              in_signal_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W:0]   out_data_o,
  output logic              seq_err_o
);
  localparam int DEPTH  = ROWS * COLS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int ACC_W  = DATA_W + MAX_LOG_N;

  frame_ctl_t        frm_ctl;
  logic [LOGN_W-1:0] cur_log;
  logic              ped_full, err_set, pix_is_data;
  logic [ADDR_W-1:0] pix_addr;
  logic [ACC_W-1:0]  ped_stored, sig_sum;
  logic [DATA_W-1:0] ped_avg, sig_avg;
  logic [DATA_W:0]   diff;
  logic              emit, err_q, out_valid_q;
  logic [DATA_W:0]   out_data_q;

  fowler_frame_seq #(.MAX_LOG_N(MAX_LOG_N), .LOGN_W(LOGN_W)) u_seq (
    .clk_i, .rst_ni,
    .beat_i(in_valid_i), .sof_i(in_sof_i), .tag_sig_i(in_signal_i),
    .raw_i(cfg_raw_i), .log_n_i(cfg_log_n_i),
    .ctl_o(frm_ctl), .log_o(cur_log), .ped_full_o(ped_full), .err_o(err_set)
  );

  fowler_pix_count #(.ROWS(ROWS), .COLS(COLS)) u_pix (
    .clk_i, .rst_ni,
    .beat_i(in_valid_i), .sof_i(in_sof_i),
    .is_data_o(pix_is_data), .addr_o(pix_addr)
  );

  fowler_acc_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_SUM(1'b0)) u_ped (
    .clk_i, .we_i(pix_is_data && frm_ctl.mode == FM_PED), .first_i(frm_ctl.first),
    .addr_i(pix_addr), .data_i(in_data_i), .q_o(ped_stored)
  );

  fowler_acc_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_SUM(1'b1)) u_sig (
    .clk_i, .we_i(pix_is_data && frm_ctl.mode == FM_SIG), .first_i(frm_ctl.first),
    .addr_i(pix_addr), .data_i(in_data_i), .q_o(sig_sum)
  );

  // averages fit DATA_W since each sum is at most N full-scale samples
  assign ped_avg = DATA_W'(ped_stored >> cur_log);
  assign sig_avg = DATA_W'(sig_sum >> cur_log);
  assign diff    = {1'b0, sig_avg} - {1'b0, ped_avg};
  assign emit    = pix_is_data &&
                   ((frm_ctl.mode == FM_SIG && frm_ctl.last) || frm_ctl.mode == FM_RAW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      out_valid_q <= emit;
      if (emit) out_data_q <= (frm_ctl.mode == FM_RAW) ? {1'b0, in_data_i} : diff;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign seq_err_o   = err_q;
endmodule

// File: rtl/fowler_differencer_chk.sv
module fowler_differencer_chk
  import fowler_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_raw_i,
  input logic              in_valid_i,
  input logic              in_sof_i,
  input logic              in_signal_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [DATA_W:0]   out_data_o,
  input logic              seq_err_o,
  input logic              pix_data_i,
  input frame_mode_e       mode_i,
  input logic              ped_full_i
);
  assert_out_from_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(pix_data_i));

  assert_raw_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(mode_i) == FM_RAW) |-> out_data_o == {1'b0, $past(in_data_i)});

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);

  assert_early_signal_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && in_signal_i && !cfg_raw_i && !ped_full_i) |=> seq_err_o);

  assert_no_out_pedestal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_data_i && mode_i == FM_PED) |=> !out_valid_o);
endmodule

bind fowler_differencer fowler_differencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_raw_i(cfg_raw_i),
  .in_valid_i(in_valid_i), .in_sof_i(in_sof_i), .in_signal_i(in_signal_i),
  .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .seq_err_o(seq_err_o), .pix_data_i(pix_is_data), .mode_i(frm_ctl.mode),
  .ped_full_i(ped_full)
);

// File: tb/fowler_differencer_test.sv
module fowler_differencer_test;
  localparam int DATA_W = 12;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int FRAME  = (ROWS + 1) * COLS;
  localparam int NPIX   = ROWS * COLS;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        cfg_log_n_i = '0;
  logic              cfg_raw_i = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_sof_i = 1'b0;
  logic              in_signal_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              out_valid_o;
  logic [DATA_W:0]   out_data_o;
  logic              seq_err_o;

  always #5 clk_i = ~clk_i;

  fowler_differencer #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)) uut (.*);

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // behavioural reference
  int ped_s [NPIX];
  int sig_s [NPIX];
  int m_ped, m_sig, m_log, m_mode, m_pix;
  bit m_first, m_last;
  bit exp_v, exp_err;
  int exp_d;

  task automatic model_reset();
    m_ped = 0; m_sig = 0; m_log = 0; m_mode = 0; m_pix = FRAME;
    m_first = 0; m_last = 0; exp_v = 0; exp_err = 0; exp_d = 0;
  endtask

  task automatic compare();
    checks++;
    if (out_valid_o !== exp_v || seq_err_o !== exp_err ||
        (exp_v && $signed(out_data_o) !== exp_d)) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%0d err=%0b expected valid=%0b data=%0d err=%0b",
               cur_req, out_valid_o, $signed(out_data_o), seq_err_o, exp_v, exp_d, exp_err);
    end
  endtask

  task automatic beat(input bit v, input bit sof, input bit sig, input bit raw,
                      input int d, input int logn);
    int idx, a, n;
    @(negedge clk_i);
    compare();
    in_valid_i = v; in_sof_i = sof; in_signal_i = sig; cfg_raw_i = raw;
    cfg_log_n_i = 2'(logn); in_data_i = DATA_W'(d);
    exp_v = 0;
    if (v) begin
      if (sof) begin
        m_first = 0; m_last = 0;
        if (raw) begin
          m_mode = sig ? 3 : 0; m_ped = 0; m_sig = 0;
        end else if (!sig) begin
          m_mode = 1;
          if (m_sig != 0 || m_ped == 0 || m_ped >= (1 << m_log)) begin
            if (m_sig != 0) exp_err = 1;
            m_first = 1; m_log = logn; m_ped = 1; m_sig = 0;
          end else m_ped++;
        end else if (m_ped != (1 << m_log)) begin
          m_mode = 0; exp_err = 1;
        end else begin
          m_mode = 2; m_first = (m_sig == 0); m_last = (m_sig == (1 << m_log) - 1);
          if (m_last) begin m_ped = 0; m_sig = 0; end else m_sig++;
        end
      end
      idx = sof ? 0 : m_pix;
      m_pix = (idx + 1 > FRAME) ? FRAME : idx + 1;
      if (idx >= COLS && idx < FRAME) begin
        a = idx - COLS;
        n = 1 << m_log;
        case (m_mode)
          1: ped_s[a] = m_first ? d : ped_s[a] + d;
          2: begin
            sig_s[a] = m_first ? d : sig_s[a] + d;
            if (m_last) begin exp_v = 1; exp_d = sig_s[a] / n - ped_s[a] / n; end
          end
          3: begin exp_v = 1; exp_d = d; end
          default: ;
        endcase
      end
    end
  endtask

  function automatic int pixval(input int seed, input int i);
    if (seed == -1) return 4095;
    if (seed == -2) return 0;
    return (seed * 97 + i * 131 + i * i * 7) % 4096;
  endfunction

  task automatic send_frame(input bit sig, input bit raw, input int logn,
                            input int seed, input bit gaps);
    for (int i = 0; i < FRAME; i++) begin
      if (gaps && (i % 3 == 1)) beat(0, 0, ~sig, raw, 1234, logn);  // ignored beat
      beat(1, i == 0, sig, raw, (i < COLS) ? 3000 + i : pixval(seed, i), logn);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; in_valid_i = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0 || seq_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset valid=%0b err=%0b expected 0 0", out_valid_o, seq_err_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0 || seq_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset valid=%0b err=%0b expected 0 0", out_valid_o, seq_err_o);
    end
  endtask

  initial begin
    do_reset();

    cur_req = "R4,R5";
    send_frame(0, 0, 0, 1, 0);
    send_frame(1, 0, 0, 2, 0);
    idle(2);

    cur_req = "R3,R11";
    for (int f = 0; f < 4; f++) send_frame(0, 0, 2, 3 + f, 0);
    for (int f = 0; f < 4; f++) send_frame(1, 0, 1, 7 + f, 0);  // cfg change mid-sequence ignored
    idle(2);

    cur_req = "R3";
    for (int f = 0; f < 8; f++) send_frame(0, 0, 3, -2, 0);
    for (int f = 0; f < 8; f++) send_frame(1, 0, 3, -1, 0);
    for (int f = 0; f < 8; f++) send_frame(0, 0, 3, -1, 0);
    for (int f = 0; f < 8; f++) send_frame(1, 0, 3, -2, 0);
    idle(2);

    cur_req = "R2,R10";
    send_frame(0, 0, 1, 11, 1);
    send_frame(0, 0, 1, 12, 1);
    send_frame(1, 0, 1, 13, 1);
    send_frame(1, 0, 1, 14, 1);
    idle(2);

    cur_req = "R6";
    send_frame(0, 0, 1, 15, 0);
    send_frame(0, 0, 1, 16, 0);
    send_frame(0, 0, 1, 17, 0);
    send_frame(1, 0, 1, 18, 0);
    send_frame(1, 0, 1, 19, 0);
    idle(2);

    cur_req = "R7";
    send_frame(0, 1, 0, 20, 0);
    send_frame(1, 1, 0, 21, 0);
    idle(2);

    cur_req = "R8";
    send_frame(0, 0, 1, 22, 0);
    send_frame(0, 0, 1, 23, 0);
    send_frame(1, 0, 1, 24, 0);
    send_frame(0, 0, 1, 25, 0);
    send_frame(0, 0, 1, 26, 0);
    send_frame(1, 0, 1, 27, 0);
    send_frame(1, 0, 1, 28, 0);
    idle(4);

    do_reset();
    cur_req = "R9";
    send_frame(1, 0, 0, 29, 0);
    idle(2);
    send_frame(0, 0, 0, 30, 0);
    send_frame(1, 0, 0, 31, 0);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule